// File: doc/BRIEF.md
# HDLC receive frame length limiter

This block sits behind an HDLC deframer and counts the bytes of each received frame. A programmable ceiling, set in units of 32-byte blocks, bounds the frame length whenever the length check is switched on. A frame that grows past the ceiling is cut off and reported to software in the same way as a frame the remote station aborted: a one-cycle end-of-message interrupt is raised and a sticky abort flag is set.

Software tells a length violation apart from a genuine remote abort by reading the byte count. After a length violation the count stops exactly one byte past the ceiling. The block then ignores everything the deframer delivers until the next start-of-frame marker. When the check is off, frames of any length finish normally, and the counter holds at its all-ones value instead of wrapping.

Top module: `rx_len_guard`

## Requirements
- R1: After reset, byte_cnt is 0, eom_irq is 0 and abort_flag is 0.
- R2: sof clears byte_cnt and opens a frame. A byte_vld in the same cycle counts as the first byte, so byte_cnt becomes 1.
- R3: Inside an open frame, each cycle with byte_vld high adds one to byte_cnt. byte_vld outside a frame (before the first sof, or after the frame has ended) leaves byte_cnt unchanged.
- R4: An eof inside an open frame closes it. eom_irq is high for exactly the one cycle after the eof edge, and abort_flag is unchanged.
- R5: The ceiling is (max_blocks + 1) * 32 bytes. With chk_en high, the byte that would make the count exceed the ceiling ends the frame. byte_cnt then reads ceiling + 1, eom_irq pulses in the next cycle and abort_flag is set.
- R6: After a length termination, byte_vld and eof have no effect until the next sof: byte_cnt holds and eom_irq stays low.
- R7: With chk_en low, a frame longer than the ceiling still ends normally on eof and does not set abort_flag.
- R8: rx_abort inside an open frame closes it, pulses eom_irq and sets abort_flag.
- R9: abort_flag stays set until an abort_clr pulse clears it. If a new abort and abort_clr arrive in the same cycle, the flag stays set.
- R10: byte_cnt saturates at 65535 and does not wrap.
- R11: With chk_en high, a frame of exactly the ceiling length that ends with eof closes normally, with byte_cnt equal to the ceiling and abort_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One received byte per high cycle |
| sof | input | 1 | Start-of-frame marker from the deframer |
| eof | input | 1 | End-of-frame marker from the deframer |
| rx_abort | input | 1 | Abort sequence seen from the remote station |
| chk_en | input | 1 | Enables the length check |
| max_blocks | input | 7 | Ceiling in 32-byte blocks, minus one |
| abort_clr | input | 1 | Write-one-to-clear strobe for abort_flag |
| byte_cnt | output | 16 | Bytes received in the current or last frame |
| eom_irq | output | 1 | One-cycle end-of-message interrupt |
| abort_flag | output | 1 | Sticky abort status |

## Verification
Directed frames are used for the edge cases:
- Frames ending one byte short of the ceiling, exactly at it, and past it. These separate an off-by-one in the comparison from a correct cut at ceiling + 1.
- Stray bytes and a late eof after a cut. These show whether the discard state really holds the count and the interrupt.
- A remote abort and a clear strobe arriving in the same cycle, which fixes the set-over-clear priority.
- A frame longer than 65535 bytes with the check off, which exposes wrapping.

A long constrained-random run then covers the cases the directed frames do not pin down. It mixes random ceilings, random enable settings, gaps and stray bytes between frames, aborts and clears. All three outputs are compared with a bench model on every cycle, which catches ordering faults where sof, eof, abort and a byte fall in the same cycle.

// File: rtl/rx_len_guard_pkg.sv
package rx_len_guard_pkg;
   typedef enum logic [1:0] {
      RLG_IDLE    = 2'd0,
      RLG_ACTIVE  = 2'd1,
      RLG_DISCARD = 2'd2
   } rlg_state_e;
endpackage

// File: rtl/rlg_counter.sv
module rlg_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= inc ? CNT_W'(1) : '0;
      end else if (inc && cnt != CNT_MAX) begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/rlg_limit.sv
module rlg_limit #(
   parameter int RL_W     = 7,
   parameter int BLK_LOG2 = 5,
   parameter int CNT_W    = 16
) (
   input  logic [RL_W-1:0]  rl,
   input  logic [CNT_W-1:0] cnt,
   output logic             at_ceiling
);
   localparam int LIM_W = RL_W + 1 + BLK_LOG2;

   logic [RL_W:0]      rl_p1;
   logic [LIM_W-1:0]   lim;

   assign rl_p1 = {1'b0, rl} + (RL_W+1)'(1);

   generate
      if (BLK_LOG2 == 0) begin : g_unit
         assign lim = rl_p1;
      end else begin : g_blocks
         assign lim = {rl_p1, {BLK_LOG2{1'b0}}};
      end
   endgenerate

   assign at_ceiling = cnt >= CNT_W'(lim);
endmodule

// File: rtl/rlg_ctrl.sv
module rlg_ctrl
   import rx_len_guard_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic byte_vld,
   input  logic sof,
   input  logic eof,
   input  logic rx_abort,
   input  logic chk_en,
   input  logic abort_clr,
   input  logic at_ceiling,
   output logic cnt_clr,
   output logic cnt_inc,
   output logic eom_irq,
   output logic abort_flag
);
   rlg_state_e state, state_nx;
   logic in_frame, over, rem_abort, end_norm;

   always_comb begin
      in_frame  = sof || (state == RLG_ACTIVE);
      over      = (state == RLG_ACTIVE) && byte_vld && chk_en && at_ceiling;
      rem_abort = in_frame && rx_abort && !over;
      end_norm  = in_frame && eof && !over && !rx_abort;
      cnt_clr   = sof;
      cnt_inc   = byte_vld && in_frame;

      state_nx = state;
      if (over)                       state_nx = RLG_DISCARD;
      else if (rem_abort || end_norm) state_nx = RLG_IDLE;
      else if (sof)                   state_nx = RLG_ACTIVE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RLG_IDLE;
         eom_irq    <= 1'b0;
         abort_flag <= 1'b0;
      end else begin
         state   <= state_nx;
         eom_irq <= over || rem_abort || end_norm;
         if (over || rem_abort)  abort_flag <= 1'b1;
         else if (abort_clr)     abort_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/rx_len_guard.sv
module rx_len_guard #(
   parameter int CNT_W    = 16,
   parameter int RL_W     = 7,
   parameter int BLK_LOG2 = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic             sof,
   input  logic             eof,
   input  logic             rx_abort,
   input  logic             chk_en,
   input  logic [RL_W-1:0]  max_blocks,
   input  logic             abort_clr,
   output logic [CNT_W-1:0] byte_cnt,
   output logic             eom_irq,
   output logic             abort_flag
);
   localparam int LIM_W = RL_W + 1 + BLK_LOG2;

   generate
      if (CNT_W <= LIM_W) begin : g_bad_cnt_w
         $error("rx_len_guard: CNT_W must exceed the ceiling width");
      end
      if (RL_W < 1) begin : g_bad_rl_w
         $error("rx_len_guard: RL_W must be at least 1");
      end
   endgenerate

   logic at_ceiling, cnt_clr, cnt_inc;

   rlg_limit #(.RL_W(RL_W), .BLK_LOG2(BLK_LOG2), .CNT_W(CNT_W)) u_limit (
      .rl(max_blocks), .cnt(byte_cnt), .at_ceiling(at_ceiling)
   );

   rlg_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .eof(eof),
      .rx_abort(rx_abort), .chk_en(chk_en), .abort_clr(abort_clr),
      .at_ceiling(at_ceiling), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
      .eom_irq(eom_irq), .abort_flag(abort_flag)
   );

   rlg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(byte_cnt)
   );
endmodule

// File: rtl/rx_len_guard_chk.sv
module rx_len_guard_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sof,
   input logic             byte_vld,
   input logic             abort_clr,
   input logic [CNT_W-1:0] byte_cnt,
   input logic             eom_irq,
   input logic             abort_flag
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   assert_sof_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> byte_cnt <= CNT_W'(1));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof && !byte_vld) |=> $stable(byte_cnt));

   assert_abort_with_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_flag) |-> eom_irq);

   assert_sticky_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_flag && !abort_clr) |=> abort_flag);

   assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_cnt == CNT_MAX && !sof) |=> byte_cnt == CNT_MAX);

   assert_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sof |=> byte_cnt >= $past(byte_cnt));
endmodule

bind rx_len_guard rx_len_guard_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
   .abort_clr(abort_clr), .byte_cnt(byte_cnt), .eom_irq(eom_irq),
   .abort_flag(abort_flag)
);

// File: tb/rx_len_guard_test.sv
module rx_len_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_vld = 0, sof = 0, eof = 0, rx_abort = 0, chk_en = 0, abort_clr = 0;
   logic [6:0]  max_blocks = '0;
   logic [15:0] byte_cnt;
   logic        eom_irq, abort_flag;

   int n_chk = 0, n_fail = 0, cycles = 0;
   int m_st = 0, m_cnt = 0;
   bit m_irq = 0, m_flag = 0, auto_cmp = 0;
   string auto_tag = "";

   rx_len_guard uut (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .eof(eof),
      .rx_abort(rx_abort), .chk_en(chk_en), .max_blocks(max_blocks),
      .abort_clr(abort_clr), .byte_cnt(byte_cnt), .eom_irq(eom_irq),
      .abort_flag(abort_flag)
   );

   always #5 clk = ~clk;

   function automatic int ceiling_of(input int rl);
      return (rl + 1) * 32;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // One clock: drive at negedge, update model at edge, compare at next negedge
   task automatic cyc(input bit s, input bit e, input bit v, input bit a, input bit c);
      int  lim;
      bit  inf, over, rab, endn;
      int  n_cnt, n_st;
      sof = s; eof = e; byte_vld = v; rx_abort = a; abort_clr = c;
      lim  = ceiling_of(int'(max_blocks));
      inf  = s || (m_st == 1);
      over = (m_st == 1) && v && chk_en && (m_cnt >= lim);
      rab  = inf && a && !over;
      endn = inf && e && !over && !a;
      n_cnt = m_cnt;
      if (s) n_cnt = v ? 1 : 0;
      else if (m_st == 1 && v && m_cnt < 65535) n_cnt = m_cnt + 1;
      n_st = m_st;
      if (over) n_st = 2;
      else if (rab || endn) n_st = 0;
      else if (s) n_st = 1;
      @(posedge clk);
      m_cnt = n_cnt; m_st = n_st;
      m_irq = over || rab || endn;
      if (over || rab) m_flag = 1;
      else if (c) m_flag = 0;
      @(negedge clk);
      if (auto_cmp) begin
         check({auto_tag, " byte_cnt"}, int'(byte_cnt), m_cnt);
         check({auto_tag, " eom_irq"}, int'(eom_irq), int'(m_irq));
         check({auto_tag, " abort_flag"}, int'(abort_flag), int'(m_flag));
      end
   endtask

   task automatic bytes(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            summary();
         end
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1 byte_cnt", int'(byte_cnt), 0);
      check("R1 eom_irq", int'(eom_irq), 0);
      check("R1 abort_flag", int'(abort_flag), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: stray bytes before any frame
      bytes(3);
      check("R3 stray before sof", int'(byte_cnt), 0);

      // R2, R4: sof with byte, then 4 more, eof
      chk_en = 0;
      cyc(1, 0, 1, 0, 0);
      check("R2 sof+byte", int'(byte_cnt), 1);
      bytes(4);
      check("R3 counted", int'(byte_cnt), 5);
      cyc(0, 1, 0, 0, 0);
      check("R4 irq after eof", int'(eom_irq), 1);
      check("R4 flag unchanged", int'(abort_flag), 0);
      cyc(0, 0, 0, 0, 0);
      check("R4 irq one cycle", int'(eom_irq), 0);
      bytes(2);
      check("R3 bytes after eof ignored", int'(byte_cnt), 5);

      // R5: ceiling 32, 40 bytes offered
      chk_en = 1; max_blocks = 7'd0;
      cyc(1, 0, 0, 0, 0);
      check("R2 sof clears", int'(byte_cnt), 0);
      bytes(32);
      check("R5 at ceiling", int'(eom_irq) + int'(abort_flag), 0);
      cyc(0, 0, 1, 0, 0);
      check("R5 count ceiling+1", int'(byte_cnt), 33);
      check("R5 irq", int'(eom_irq), 1);
      check("R5 flag", int'(abort_flag), 1);
      bytes(7);
      check("R6 bytes ignored", int'(byte_cnt), 33);
      cyc(0, 1, 0, 0, 0);
      check("R6 eof no irq", int'(eom_irq), 0);

      // R9 clear
      cyc(0, 0, 0, 0, 1);
      check("R9 clear", int'(abort_flag), 0);

      // R11: exactly ceiling 128 with eof on last byte
      max_blocks = 7'd3;
      cyc(1, 0, 1, 0, 0);
      bytes(126);
      cyc(0, 1, 1, 0, 0);
      check("R11 count", int'(byte_cnt), 128);
      check("R11 irq", int'(eom_irq), 1);
      check("R11 no flag", int'(abort_flag), 0);

      // R7: check off, 200 bytes with ceiling 32
      chk_en = 0; max_blocks = 7'd0;
      cyc(1, 0, 0, 0, 0);
      bytes(200);
      cyc(0, 1, 0, 0, 0);
      check("R7 count", int'(byte_cnt), 200);
      check("R7 irq", int'(eom_irq), 1);
      check("R7 no flag", int'(abort_flag), 0);

      // R8 remote abort, R9 set beats clear
      cyc(1, 0, 1, 0, 0);
      cyc(0, 0, 0, 1, 1);
      check("R8 irq", int'(eom_irq), 1);
      check("R9 set over clear", int'(abort_flag), 1);
      cyc(0, 0, 0, 0, 0);
      check("R9 sticky", int'(abort_flag), 1);
      cyc(0, 0, 0, 1, 0);
      check("R8 abort outside frame no irq", int'(eom_irq), 0);
      cyc(0, 0, 0, 0, 1);

      // R10 saturation
      chk_en = 0;
      cyc(1, 0, 0, 0, 0);
      bytes(65540);
      check("R10 saturates", int'(byte_cnt), 65535);
      cyc(0, 1, 0, 0, 0);

      // Random phase, compared every cycle (R3 R4 R5 R6 R7 R8 R9)
      auto_cmp = 1; auto_tag = "random R5";
      for (int f = 0; f < 300; f++) begin
         int len;
         max_blocks = 7'($urandom_range(0, 2));
         chk_en = $urandom_range(0, 1) != 0;
         len = $urandom_range(0, 120);
         for (int g = $urandom_range(0, 3); g > 0; g--)
            cyc(0, $urandom_range(0, 4) == 0, $urandom_range(0, 1) != 0, 0,
                $urandom_range(0, 9) == 0);
         cyc(1, 0, $urandom_range(0, 1) != 0, 0, 0);
         for (int i = 0; i < len; i++)
            cyc(0, 0, $urandom_range(0, 9) < 7, $urandom_range(0, 199) == 0,
                $urandom_range(0, 19) == 0);
         cyc(0, 1, $urandom_range(0, 1) != 0, $urandom_range(0, 19) == 0, 0);
      end
      auto_cmp = 0;
      summary();
   end
endmodule